// File: doc/BRIEF.md
# Configuration Cycle Master

This block lets a processor issue one configuration or I/O transaction at a time onto a downstream bus through a small register window. Software writes a target selector (bus number, device/function number and register offset) and, for writes, a data word. It then writes the control register with the start bit, the command code and the active-low byte enables. The engine forms the configuration address, presents a single request to the target port and holds it until the target acknowledges, the target reports a master abort, or a programmable timeout expires. The outcome appears as flags in a status register that software clears by writing ones.

The address is type 0 when the bus number is zero and type 1 otherwise (bit 0 set), with the offset forced to a dword boundary. A read that ends in an abort or a timeout returns all ones, so a missing device reads as 0xFFFFFFFF. The target port follows valid/ready rules: `tgt_req` is the valid and, once raised, holds with every request field stable until a cycle in which `tgt_ack` or `tgt_abort` is sampled high, or until the timeout drops it. The target applies back-pressure only by delaying its response. The register side has no back-pressure: every write takes effect at the clock edge that samples it, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `cfg_cycle_master`

## Requirements
- R1: The target address carries the selector's bus number (selector bits 23:16) at address bits 23:16, the device/function number (selector bits 15:8) at address bits 15:8, and selector bits 7:2 at address bits 7:2. Address bit 1 is 0. Address bit 0 is 1 exactly when the bus number is nonzero.
- R2: A write to the control register (word 2) with bit 31 set starts a cycle. Bits 7:4 give the command and bits 3:0 the active-low byte enables (0 enables all four lanes). `tgt_req` rises at the edge that samples the write and carries these values unchanged while it is high. A control write with bit 31 clear starts nothing.
- R3: The accepted command codes are 0x2 I/O read, 0x3 I/O write, 0xA configuration read and 0xB configuration write. A start with any other code raises no request and sets the error flag (status bit 3).
- R4: For the two write commands, `tgt_wdata` equals the write-data register (word 1). For the two read commands, it is zero.
- R5: When a read is acknowledged, the read-data register (word 5) takes `tgt_rdata`. An acknowledged write leaves the read-data register unchanged.
- R6: `tgt_abort` without `tgt_ack` ends the cycle and sets the abort flag (status bit 1). An aborted read loads 0xFFFFFFFF into the read-data register, and an aborted write leaves it unchanged. When both responses are high, `tgt_ack` wins.
- R7: The timeout limit register (word 6, reset value 16) bounds the wait. With a nonzero limit N and no response, `tgt_req` is high for exactly N cycles, after which the timeout flag (status bit 2) is set and a read loads 0xFFFFFFFF. A limit of 0 disables the timeout.
- R8: Status (word 3) bit 0 is set when a cycle is acknowledged, and bit 4 shows a cycle in progress. Each flag is readable in the cycle after the edge that ended the cycle. All status bits are 0 after reset.
- R9: A write to the clear register (word 4) clears the status bits 3:0 that are set in the written value and leaves the others as they were.
- R10: While a cycle is in progress, writes to the control and timeout-limit registers are ignored. A control write with bit 31 set during that time sets the sticky error flag (status bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tgt_req | output | 1 | Request valid toward the target |
| tgt_cmd | output | 4 | Bus command code of the request |
| tgt_addr | output | 32 | Formed configuration/I/O address |
| tgt_be_n | output | 4 | Active-low byte enables |
| tgt_wdata | output | 32 | Write data (zero for reads) |
| tgt_ack | input | 1 | Target completes the request |
| tgt_abort | input | 1 | Target reports master abort |
| tgt_rdata | input | 32 | Read data, valid with `tgt_ack` |

## Verification
Every outcome is due one edge after its cause. The request is high in the cycle after the edge that samples the control write, and the status flags and read data change one edge after the edge that samples a response or the last timeout cycle. The bench drives inputs and reads registers on the falling edge, which places every sample between two active edges. It looks at status in the cycle of the acknowledge and again in the cycle after it, so a response that is a cycle early or late is caught. The target model counts the request cycles, which checks the timeout length exactly.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int DW = 32;
  localparam int RAW = 3;

  localparam logic [RAW-1:0] RA_SEL    = 3'd0;
  localparam logic [RAW-1:0] RA_WDATA  = 3'd1;
  localparam logic [RAW-1:0] RA_CTRL   = 3'd2;
  localparam logic [RAW-1:0] RA_STATUS = 3'd3;
  localparam logic [RAW-1:0] RA_CLEAR  = 3'd4;
  localparam logic [RAW-1:0] RA_RDATA  = 3'd5;
  localparam logic [RAW-1:0] RA_TMO    = 3'd6;

  localparam int CTRL_START = 31;
  localparam int SEL_BUS_LSB = 16;
  localparam int SEL_FN_LSB  = 8;

  localparam logic [3:0] CMD_IORD  = 4'h2;
  localparam logic [3:0] CMD_IOWR  = 4'h3;
  localparam logic [3:0] CMD_CFGRD = 4'hA;
  localparam logic [3:0] CMD_CFGWR = 4'hB;

  localparam int ST_DONE    = 0;
  localparam int ST_ABORT   = 1;
  localparam int ST_TMO     = 2;
  localparam int ST_ERR     = 3;
  localparam int ST_BUSY    = 4;
  localparam int NFLAG      = 4;
  localparam int STW        = 5;

  typedef enum logic {SQ_IDLE, SQ_WAIT} seq_state_e;

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == CMD_IORD) || (c == CMD_CFGRD);
  endfunction

  function automatic logic cmd_is_write(input logic [3:0] c);
    return (c == CMD_IOWR) || (c == CMD_CFGWR);
  endfunction

  function automatic logic cmd_known(input logic [3:0] c);
    return cmd_is_read(c) || cmd_is_write(c);
  endfunction
endpackage

// File: rtl/ccm_addr_gen.sv
module ccm_addr_gen
  import ccm_pkg::*;
#(
  parameter int BUS_SHIFT  = 16,
  parameter int FUNC_SHIFT = 8
) (
  input  logic [23:0]   sel,
  output logic [DW-1:0] addr
);
  logic [7:0] bus_num;
  logic [7:0] dev_fn;
  logic [7:0] reg_off;
  logic       far_bus;

  assign bus_num = sel[SEL_BUS_LSB +: 8];
  assign dev_fn  = sel[SEL_FN_LSB +: 8];
  assign reg_off = sel[7:0] & 8'hFC;
  assign far_bus = (bus_num != 8'h00);

  always_comb begin
    addr = (DW'(bus_num) << BUS_SHIFT)
         | (DW'(dev_fn) << FUNC_SHIFT)
         | DW'(reg_off)
         | DW'(far_bus);
  end
endmodule

// File: rtl/ccm_seq.sv
module ccm_seq
  import ccm_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [3:0]    l_cmd,
  input  logic [3:0]    l_be_n,
  input  logic [DW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic [TW-1:0] l_limit,
  input  logic          tgt_ack,
  input  logic          tgt_abort,
  output logic          tgt_req,
  output logic [3:0]    tgt_cmd,
  output logic [DW-1:0] tgt_addr,
  output logic [3:0]    tgt_be_n,
  output logic [DW-1:0] tgt_wdata,
  output logic          busy,
  output logic          ev_ack,
  output logic          ev_abort,
  output logic          ev_tmo
);
  seq_state_e    st_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;
  logic          waiting;
  logic          any_end;

  assign waiting  = (st_q == SQ_WAIT);
  assign ev_ack   = waiting && tgt_ack;
  assign ev_abort = waiting && !tgt_ack && tgt_abort;
  assign ev_tmo   = waiting && !tgt_ack && !tgt_abort &&
                    (lim_q != '0) && (cnt_q == lim_q - TW'(1));
  assign any_end  = ev_ack || ev_abort || ev_tmo;
  assign tgt_req  = waiting;
  assign busy     = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      lim_q     <= '0;
      tgt_cmd   <= '0;
      tgt_addr  <= '0;
      tgt_be_n  <= '1;
      tgt_wdata <= '0;
    end else if (launch && !waiting) begin
      st_q      <= SQ_WAIT;
      cnt_q     <= '0;
      lim_q     <= l_limit;
      tgt_cmd   <= l_cmd;
      tgt_addr  <= l_addr;
      tgt_be_n  <= l_be_n;
      tgt_wdata <= cmd_is_write(l_cmd) ? l_wdata : '0;
    end else if (waiting) begin
      if (any_end) begin
        st_q  <= SQ_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/ccm_regs.sv
module ccm_regs
  import ccm_pkg::*;
#(
  parameter int          TW      = 16,
  parameter int unsigned DEF_TMO = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           busy,
  input  logic           ev_ack,
  input  logic           ev_abort,
  input  logic           ev_tmo,
  input  logic [3:0]     cur_cmd,
  input  logic [DW-1:0]  tgt_rdata,
  output logic           launch,
  output logic [3:0]     l_cmd,
  output logic [3:0]     l_be_n,
  output logic [DW-1:0]  sel_q,
  output logic [DW-1:0]  wdata_q,
  output logic [TW-1:0]  limit_q,
  output logic [STW-1:0] stat_vec
);
  logic [7:0]       ctrl_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [DW-1:0]    rdata_q;
  logic             wr_ctrl;
  logic             ctrl_ok;
  logic             start_req;
  logic             bad_cmd;
  logic             busy_hit;
  logic             cur_rd;

  assign l_cmd     = reg_wdata[7:4];
  assign l_be_n    = reg_wdata[3:0];
  assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
  assign ctrl_ok   = wr_ctrl && !busy;
  assign start_req = ctrl_ok && reg_wdata[CTRL_START];
  assign launch    = start_req && cmd_known(l_cmd);
  assign bad_cmd   = start_req && !cmd_known(l_cmd);
  assign busy_hit  = wr_ctrl && busy && reg_wdata[CTRL_START];
  assign cur_rd    = cmd_is_read(cur_cmd);

  assign flag_clr = (reg_we && (reg_addr == RA_CLEAR)) ? reg_wdata[NFLAG-1:0] : '0;

  always_comb begin
    flag_set           = '0;
    flag_set[ST_DONE]  = ev_ack;
    flag_set[ST_ABORT] = ev_abort;
    flag_set[ST_TMO]   = ev_tmo;
    flag_set[ST_ERR]   = bad_cmd || busy_hit;
  end

  assign stat_vec = {busy, flag_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      wdata_q <= '0;
      ctrl_q  <= '0;
      limit_q <= TW'(DEF_TMO);
      flag_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we && (reg_addr == RA_SEL))   sel_q   <= reg_wdata;
      if (reg_we && (reg_addr == RA_WDATA)) wdata_q <= reg_wdata;
      if (reg_we && (reg_addr == RA_TMO) && !busy) limit_q <= reg_wdata[TW-1:0];
      if (ctrl_ok) ctrl_q <= reg_wdata[7:0];
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (ev_ack && cur_rd)                  rdata_q <= tgt_rdata;
      else if ((ev_abort || ev_tmo) && cur_rd) rdata_q <= '1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SEL:    reg_rdata = sel_q;
      RA_WDATA:  reg_rdata = wdata_q;
      RA_CTRL: begin
        reg_rdata[CTRL_START] = busy;
        reg_rdata[7:0]        = ctrl_q;
      end
      RA_STATUS: reg_rdata[STW-1:0] = stat_vec;
      RA_RDATA:  reg_rdata = rdata_q;
      RA_TMO:    reg_rdata[TW-1:0] = limit_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_cycle_master.sv
module cfg_cycle_master
  import ccm_pkg::*;
#(
  parameter int          TMO_W      = 16,
  parameter int unsigned DEF_TMO    = 16,
  parameter int          BUS_SHIFT  = 16,
  parameter int          FUNC_SHIFT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tgt_req,
  output logic [3:0]    tgt_cmd,
  output logic [31:0]   tgt_addr,
  output logic [3:0]    tgt_be_n,
  output logic [31:0]   tgt_wdata,
  input  logic          tgt_ack,
  input  logic          tgt_abort,
  input  logic [31:0]   tgt_rdata
);
  logic             launch;
  logic [3:0]       l_cmd;
  logic [3:0]       l_be_n;
  logic [DW-1:0]    sel_q;
  logic [DW-1:0]    wdata_q;
  logic [TMO_W-1:0] limit_q;
  logic [STW-1:0]   stat_vec;
  logic [DW-1:0]    formed_addr;
  logic             busy;
  logic             ev_ack;
  logic             ev_abort;
  logic             ev_tmo;

  ccm_regs #(.TW(TMO_W), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .ev_ack(ev_ack), .ev_abort(ev_abort), .ev_tmo(ev_tmo),
    .cur_cmd(tgt_cmd), .tgt_rdata(tgt_rdata),
    .launch(launch), .l_cmd(l_cmd), .l_be_n(l_be_n),
    .sel_q(sel_q), .wdata_q(wdata_q), .limit_q(limit_q), .stat_vec(stat_vec)
  );

  ccm_addr_gen #(.BUS_SHIFT(BUS_SHIFT), .FUNC_SHIFT(FUNC_SHIFT)) u_addr (
    .sel(sel_q[23:0]),
    .addr(formed_addr)
  );

  ccm_seq #(.TW(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .l_cmd(l_cmd), .l_be_n(l_be_n),
    .l_addr(formed_addr), .l_wdata(wdata_q), .l_limit(limit_q),
    .tgt_ack(tgt_ack), .tgt_abort(tgt_abort),
    .tgt_req(tgt_req), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr),
    .tgt_be_n(tgt_be_n), .tgt_wdata(tgt_wdata),
    .busy(busy), .ev_ack(ev_ack), .ev_abort(ev_abort), .ev_tmo(ev_tmo)
  );
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker
  import ccm_pkg::*;
#(
  parameter int BUS_SHIFT = 16,
  parameter int TW        = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic           start_bit,
  input logic           tgt_req,
  input logic [3:0]     tgt_cmd,
  input logic [DW-1:0]  tgt_addr,
  input logic [DW-1:0]  tgt_wdata,
  input logic           tgt_ack,
  input logic           tgt_abort,
  input logic [TW-1:0]  limit,
  input logic [STW-1:0] stat
);
  logic [TW-1:0] req_cnt;
  logic          no_resp;

  assign no_resp = tgt_req && !tgt_ack && !tgt_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_cnt <= '0;
    else if (no_resp) req_cnt <= req_cnt + TW'(1);
    else              req_cnt <= '0;
  end

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (!tgt_addr[1] && (tgt_addr[0] == (tgt_addr[BUS_SHIFT +: 8] != 8'h00)))); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_resp && ((limit == '0) || (req_cnt != limit - TW'(1))))
      |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_cmd))); // R2

  AST_RD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && cmd_is_read(tgt_cmd)) |-> (tgt_wdata == '0)); // R4

  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack && tgt_abort) |=> (stat[ST_ABORT] && !tgt_req)); // R6

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && (limit != '0)) |-> (req_cnt < limit)); // R7

  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (no_resp && (limit != '0) && (req_cnt == limit - TW'(1))) |=> (stat[ST_TMO] && !tgt_req)); // R7

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_ack) |=> (stat[ST_DONE] && !stat[ST_BUSY] && !tgt_req)); // R8

  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == RA_CTRL) && start_bit && tgt_req) |=> stat[ST_ERR]); // R10
endmodule

bind cfg_cycle_master ccm_checker #(.BUS_SHIFT(BUS_SHIFT), .TW(TMO_W)) u_ccm_checker (
  .clk(clk), .rst_n(rst_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .start_bit(reg_wdata[31]),
  .tgt_req(tgt_req), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
  .tgt_ack(tgt_ack), .tgt_abort(tgt_abort),
  .limit(limit_q), .stat(stat_vec)
);

// File: tb/test_cfg_cycle_master.sv
`timescale 1ns/1ps
module test_cfg_cycle_master;
  import ccm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tgt_req;
  logic [3:0]  tgt_cmd;
  logic [31:0] tgt_addr;
  logic [3:0]  tgt_be_n;
  logic [31:0] tgt_wdata;
  logic        tgt_ack = 1'b0;
  logic        tgt_abort = 1'b0;
  logic [31:0] tgt_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // target model controls: 0 ack, 1 abort, 2 silent, 3 ack and abort together
  int          mode = 0;
  int          delay = 0;
  int          cyc = 0;
  int          req_len = 0;
  logic [31:0] cap_addr, cap_wd;
  logic [3:0]  cap_cmd, cap_be;

  always #2.5 clk = ~clk;

  cfg_cycle_master i_cfg_cycle_master (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tgt_req(tgt_req), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_abort(tgt_abort), .tgt_rdata(tgt_rdata)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (tgt_req) begin
        if (cyc == 0) begin
          cap_addr = tgt_addr; cap_wd = tgt_wdata;
          cap_cmd = tgt_cmd; cap_be = tgt_be_n; req_len = 0;
        end
        req_len = req_len + 1;
        if (cyc >= delay && mode != 2) begin
          tgt_ack   = (mode == 0 || mode == 3);
          tgt_abort = (mode == 1 || mode == 3);
        end
        cyc = cyc + 1;
      end else begin
        cyc = 0; tgt_ack = 1'b0; tgt_abort = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic go(input logic [3:0] cmd, input logic [3:0] be);
    wr(RA_CTRL, 32'h8000_0000 | {24'h0, cmd, be});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(RA_STATUS, s);
      if (!s[ST_BUSY]) return;
    end
    chk("R8", "cycle never ended", 32'h1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA_STATUS, v); chk("R8", "status after reset", v, 32'h0);
    chk("R8", "request after reset", {31'h0, tgt_req}, 32'h0);
    rd(RA_TMO, v);    chk("R7", "timeout limit reset value", v, 32'd16);
  endtask

  task automatic t_cfg_read_bus0();
    logic [31:0] v;
    wr(RA_SEL, 32'h0000_3A47);
    mode = 0; delay = 2; tgt_rdata = 32'hCAFE_0123;
    go(CMD_CFGRD, 4'h0);
    @(negedge clk); @(negedge clk);
    reg_addr = RA_STATUS; #0.5;
    chk("R8", "done not yet set in ack cycle", reg_rdata & 32'h1, 32'h0);
    chk("R2", "request held until response", {31'h0, tgt_req}, 32'h1);
    @(negedge clk); #0.5;
    chk("R8", "done one edge after ack", reg_rdata[4:0], 5'b00001);
    chk("R8", "request dropped after ack", {31'h0, tgt_req}, 32'h0);
    chk("R1", "type-0 address", cap_addr, 32'h0000_3A44);
    chk("R2", "command carried", {28'h0, cap_cmd}, {28'h0, CMD_CFGRD});
    chk("R2", "all lanes enabled", {28'h0, cap_be}, 32'h0);
    chk("R4", "read drives zero write data", cap_wd, 32'h0);
    rd(RA_RDATA, v); chk("R5", "read data captured", v, 32'hCAFE_0123);
    wr(RA_CLEAR, 32'hF);
    rd(RA_STATUS, v); chk("R9", "clear all flags", v, 32'h0);
  endtask

  task automatic t_cfg_write_bus7();
    logic [31:0] v;
    wr(RA_SEL, 32'h0007_10FE);
    wr(RA_WDATA, 32'h1234_5678);
    mode = 0; delay = 0; tgt_rdata = 32'hDEAD_BEEF;
    go(CMD_CFGWR, 4'hE);
    wait_idle();
    chk("R1", "type-1 address", cap_addr, 32'h0007_10FD);
    chk("R4", "write data driven", cap_wd, 32'h1234_5678);
    chk("R2", "byte enables carried", {28'h0, cap_be}, 32'hE);
    rd(RA_RDATA, v); chk("R5", "write leaves read data", v, 32'hCAFE_0123);
    rd(RA_STATUS, v); chk("R8", "write done flag", v, 32'h1);
    wr(RA_CLEAR, 32'hF);
  endtask

  task automatic t_aborts();
    logic [31:0] v;
    mode = 1; delay = 1;
    go(CMD_IORD, 4'h0);
    wait_idle();
    rd(RA_STATUS, v); chk("R6", "abort flag on read", v, 32'h2);
    rd(RA_RDATA, v);  chk("R6", "aborted read returns ones", v, 32'hFFFF_FFFF);
    wr(RA_CLEAR, 32'hF);
    mode = 0; delay = 0; tgt_rdata = 32'h55AA_55AA;
    go(CMD_CFGRD, 4'h0); wait_idle();
    wr(RA_CLEAR, 32'hF);
    mode = 1;
    go(CMD_IOWR, 4'h0); wait_idle();
    rd(RA_STATUS, v); chk("R6", "abort flag on write", v, 32'h2);
    rd(RA_RDATA, v);  chk("R6", "aborted write keeps read data", v, 32'h55AA_55AA);
    wr(RA_CLEAR, 32'hF);
    mode = 3; tgt_rdata = 32'h0F0F_0F0F;
    go(CMD_IORD, 4'h0); wait_idle();
    rd(RA_STATUS, v); chk("R6", "ack wins over abort", v, 32'h1);
    rd(RA_RDATA, v);  chk("R5", "I/O read data captured", v, 32'h0F0F_0F0F);
    wr(RA_CLEAR, 32'hF);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(RA_TMO, 32'd4);
    mode = 2;
    go(CMD_CFGRD, 4'h0); wait_idle();
    chk("R7", "request length equals limit", req_len, 32'd4);
    rd(RA_STATUS, v); chk("R7", "timeout flag", v, 32'h4);
    rd(RA_RDATA, v);  chk("R7", "timed-out read returns ones", v, 32'hFFFF_FFFF);
    wr(RA_CLEAR, 32'hF);
    wr(RA_TMO, 32'd0);
    go(CMD_CFGWR, 4'h0);
    repeat (40) @(negedge clk);
    chk("R7", "limit 0 never times out", {31'h0, tgt_req}, 32'h1);
    // busy window: control and limit writes are ignored
    wr(RA_CTRL, 32'h8000_0030);
    chk("R10", "command unchanged while busy", {28'h0, tgt_cmd}, {28'h0, CMD_CFGWR});
    wr(RA_TMO, 32'd9);
    rd(RA_TMO, v); chk("R10", "limit write ignored while busy", v, 32'h0);
    rd(RA_STATUS, v); chk("R10", "sticky error while busy", v, 32'h18);
    mode = 0; delay = 0;
    wait_idle();
    wr(RA_CLEAR, 32'h8);
    rd(RA_STATUS, v); chk("R9", "selective clear keeps done", v, 32'h1);
    wr(RA_CLEAR, 32'hF);
    wr(RA_TMO, 32'd16);
  endtask

  task automatic t_bad_and_nostart();
    logic [31:0] v;
    wr(RA_CTRL, 32'h8000_0050);
    chk("R3", "unknown command raises no request", {31'h0, tgt_req}, 32'h0);
    rd(RA_STATUS, v); chk("R3", "unknown command sets error", v, 32'h8);
    wr(RA_CLEAR, 32'hF);
    wr(RA_CTRL, 32'h0000_00A0);
    chk("R2", "no start bit, no request", {31'h0, tgt_req}, 32'h0);
    rd(RA_STATUS, v); chk("R2", "no start bit, status quiet", v, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_read_bus0();
    t_cfg_write_bus7();
    t_aborts();
    t_timeout();
    t_bad_and_nostart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule